// File: doc/BRIEF.md
# Planar Graphics Controller Datapath

This block sits between a CPU byte port and four bit planes of display memory that share one byte address. A pixel's 4-bit colour is spread across the planes: bit k of the colour lives in plane k, and the eight bits of a byte are eight neighbouring pixels. The memory itself is outside the block. The block receives the four plane bytes at the current address on `plane_rdata` and drives four plane bytes and four write strobes back. The memory captures those on the next rising clock edge.

A CPU read loads four internal latches, one per plane. It returns either the byte of one chosen plane or an 8-bit vector that marks which pixels match a compare colour. A CPU write is reshaped separately for each plane. The steps are: a rotation or a fixed fill colour, then an optional logic operation against the latches, then a per-pixel merge with the latches under a bit mask, and finally gating of each plane's strobe. Registers are loaded through an index write followed by a data write.

The CPU access port uses valid/ready handshaking. A read answers with a registered response that is valid/ready. `cpu_ready` drops while a response is waiting and `rsp_ready` is low, so at most one response is ever outstanding. Once a response is raised, it stays valid and unchanged until the consumer takes it. Writes need no response: their strobes appear in the cycle the write is accepted.

Top module: `plane_gfx_dp`

## Requirements
- R1: After reset the block holds these values: `rsp_valid` = 0, no plane strobe, `cpu_ready` = 1, all latches zero, write mode 0, read mode 0, rotate 0, function pass, set/reset and enable 0, read select 0, compare 0, map mask 4'hF, bit mask 8'hFF, don't-care 4'hF.
- R2: When `reg_wr` is high and `reg_sel` is 0, the index is loaded from `reg_wdata`. When `reg_wr` is high and `reg_sel` is 1, `reg_wdata` is written to the indexed register. The indices are:
  - 0 = mode: bits 1:0 write mode, bit 2 read mode
  - 1 = map mask, bits 3:0
  - 2 = bit mask
  - 3 = rotate: bits 2:0 count, bits 4:3 function
  - 4 = set/reset value, bits 3:0
  - 5 = set/reset enable, bits 3:0
  - 6 = read select, bits 1:0
  - 7 = compare colour, bits 3:0
  - 8 = don't-care, bits 3:0

  A data write while the index is above 8 changes nothing.
- R3: An accepted read (`cpu_valid` & `cpu_ready` & !`cpu_write`) has three effects. It loads latch k from plane k. It raises `rsp_valid` on the next cycle. It holds `rsp_valid` and `rsp_data` stable until `rsp_ready` is high. `cpu_ready` equals !`rsp_valid` | `rsp_ready`.
- R4: In read mode 0 the response is the byte of the plane named by read select.
- R5: In read mode 1, response bit b is 1 when the 4-bit colour of pixel b equals the compare colour on every plane whose don't-care bit is 1. Planes whose don't-care bit is 0 are left out of the comparison.
- R6: In write mode 0 the CPU byte is rotated right by the rotate count.
- R7: In write mode 0, a plane whose set/reset enable bit is 1 takes all ones or all zeros from its set/reset bit instead of the rotated byte.
- R8: The function field combines the mode 0 or mode 2 source with that plane's latch: 0 passes the source, 1 ANDs, 2 ORs, 3 XORs.
- R9: In write modes 0 and 2, an output bit whose bit-mask bit is 1 takes the function result. An output bit whose bit-mask bit is 0 takes the latch bit.
- R10: `plane_we[k]` is 1 only in the cycle of an accepted write, and only when map-mask bit k is 1.
- R11: In write mode 1, each plane receives its latch byte unchanged.
- R12: In write mode 2, the source for plane k is CPU data bit k copied to all 8 pixels.
- R13: A write mode value of 3 raises no plane strobe.
- R14: A register data write in the same cycle as a CPU access takes effect only for later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_sel | input | 1 | 0 selects the index, 1 selects the data register |
| reg_wdata | input | 8 | Register port write value |
| cpu_valid | input | 1 | CPU access request |
| cpu_ready | output | 1 | CPU access accepted when high together with `cpu_valid` |
| cpu_write | input | 1 | 1 for a write, 0 for a read |
| cpu_wdata | input | 8 | CPU write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response consumer ready |
| rsp_data | output | 8 | Read response byte |
| plane_rdata | input | 32 | Plane bytes at the current address, plane k in bits 8k+7:8k |
| plane_wdata | output | 32 | Plane bytes to write, same layout |
| plane_we | output | 4 | Per-plane write strobes |

## Verification
A register data write and a CPU access can land in the same cycle. The bench provokes this by pointing the index at the bit mask and then, on one clock edge, writing a new mask together with a CPU write. It judges the result by requiring that this write still uses the old mask and that the next write uses the new one. A read response held under back-pressure is another cycle-sharing case. The bench checks that `cpu_ready` stays low and the response byte stays frozen while `rsp_ready` is low.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
  localparam int PLANES = 4;
  localparam int PIX    = 8;
  localparam int PW     = PLANES * PIX;
  localparam int ROT_W  = $clog2(PIX);
  localparam int SEL_W  = $clog2(PLANES);
  localparam int IDX_W  = 8;
  localparam int NREG   = 9;

  typedef enum logic [1:0] {WM_ALU = 2'd0, WM_COPY = 2'd1, WM_FILL = 2'd2, WM_NONE = 2'd3} wmode_e;
  typedef enum logic [1:0] {FN_PASS = 2'd0, FN_AND = 2'd1, FN_OR = 2'd2, FN_XOR = 2'd3} func_e;

  typedef struct packed {
    wmode_e             wmode;
    logic               rmode;
    logic [PLANES-1:0]  map_mask;
    logic [PIX-1:0]     bit_mask;
    logic [ROT_W-1:0]   rot;
    func_e              func;
    logic [PLANES-1:0]  sr;
    logic [PLANES-1:0]  esr;
    logic [SEL_W-1:0]   rsel;
    logic [PLANES-1:0]  cmp;
    logic [PLANES-1:0]  dc;
  } regs_t;

  function automatic logic [PIX-1:0] rotr(input logic [PIX-1:0] d, input logic [ROT_W-1:0] n);
    logic [2*PIX-1:0] t;
    t = {d, d} >> n;
    return t[PIX-1:0];
  endfunction
endpackage

// File: rtl/pgd_regs.sv
module pgd_regs
  import pgd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [IDX_W-1:0] reg_wdata,
  output regs_t            regs_q
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q           <= '0;
      regs_q.wmode    <= WM_ALU;
      regs_q.rmode    <= 1'b0;
      regs_q.map_mask <= '1;
      regs_q.bit_mask <= '1;
      regs_q.rot      <= '0;
      regs_q.func     <= FN_PASS;
      regs_q.sr       <= '0;
      regs_q.esr      <= '0;
      regs_q.rsel     <= '0;
      regs_q.cmp      <= '0;
      regs_q.dc       <= '1;
    end else if (reg_wr) begin
      if (!reg_sel) begin
        idx_q <= reg_wdata;
      end else if (idx_q < IDX_W'(NREG)) begin
        case (idx_q[3:0])
          4'd0: begin
            regs_q.wmode <= wmode_e'(reg_wdata[1:0]);
            regs_q.rmode <= reg_wdata[2];
          end
          4'd1: regs_q.map_mask <= reg_wdata[PLANES-1:0];
          4'd2: regs_q.bit_mask <= reg_wdata[PIX-1:0];
          4'd3: begin
            regs_q.rot  <= reg_wdata[ROT_W-1:0];
            regs_q.func <= func_e'(reg_wdata[ROT_W+1:ROT_W]);
          end
          4'd4: regs_q.sr   <= reg_wdata[PLANES-1:0];
          4'd5: regs_q.esr  <= reg_wdata[PLANES-1:0];
          4'd6: regs_q.rsel <= reg_wdata[SEL_W-1:0];
          4'd7: regs_q.cmp  <= reg_wdata[PLANES-1:0];
          default: regs_q.dc <= reg_wdata[PLANES-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/pgd_read.sv
module pgd_read
  import pgd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_go,
  input  logic           rsp_ready,
  input  logic [PW-1:0]  plane_rdata,
  input  regs_t          regs_q,
  output logic [PW-1:0]  latch_q,
  output logic           rsp_valid,
  output logic [PIX-1:0] rsp_data
);
  logic [PIX-1:0] match;
  logic [PIX-1:0] sel_byte;

  for (genvar b = 0; b < PIX; b++) begin : g_pix
    logic [PLANES-1:0] colour;
    for (genvar p = 0; p < PLANES; p++) begin : g_pl
      assign colour[p] = plane_rdata[p*PIX + b];
    end
    assign match[b] = ((colour ^ regs_q.cmp) & regs_q.dc) == '0;
  end

  assign sel_byte = plane_rdata[regs_q.rsel*PIX +: PIX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_go) begin
      latch_q   <= plane_rdata;
      rsp_valid <= 1'b1;
      rsp_data  <= regs_q.rmode ? match : sel_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pgd_write.sv
module pgd_write
  import pgd_pkg::*;
(
  input  logic              wr_go,
  input  logic [PIX-1:0]    cpu_wdata,
  input  logic [PW-1:0]     latch_q,
  input  regs_t             regs_q,
  output logic [PW-1:0]     plane_wdata,
  output logic [PLANES-1:0] plane_we
);
  logic [PIX-1:0] rot_d;
  assign rot_d = rotr(cpu_wdata, regs_q.rot);

  for (genvar p = 0; p < PLANES; p++) begin : g_pl
    logic [PIX-1:0] lat, src, fn, mrg;
    assign lat = latch_q[p*PIX +: PIX];

    always_comb begin
      if (regs_q.wmode == WM_FILL) src = {PIX{cpu_wdata[p]}};
      else if (regs_q.esr[p])      src = {PIX{regs_q.sr[p]}};
      else                         src = rot_d;
    end

    always_comb begin
      case (regs_q.func)
        FN_AND:  fn = src & lat;
        FN_OR:   fn = src | lat;
        FN_XOR:  fn = src ^ lat;
        default: fn = src;
      endcase
    end

    assign mrg = (fn & regs_q.bit_mask) | (lat & ~regs_q.bit_mask);
    assign plane_wdata[p*PIX +: PIX] = (regs_q.wmode == WM_COPY) ? lat : mrg;
    assign plane_we[p] = wr_go && regs_q.map_mask[p] && (regs_q.wmode != WM_NONE);
  end
endmodule

// File: rtl/plane_gfx_dp.sv
module plane_gfx_dp
  import pgd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [IDX_W-1:0]  reg_wdata,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [PIX-1:0]    cpu_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PIX-1:0]    rsp_data,
  input  logic [PW-1:0]     plane_rdata,
  output logic [PW-1:0]     plane_wdata,
  output logic [PLANES-1:0] plane_we
);
  regs_t         regs_q;
  logic [PW-1:0] latch_q;
  logic          acc, rd_go, wr_go;

  assign cpu_ready = !rsp_valid || rsp_ready;
  assign acc       = cpu_valid && cpu_ready;
  assign rd_go     = acc && !cpu_write;
  assign wr_go     = acc && cpu_write;

  pgd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .regs_q(regs_q)
  );

  pgd_read u_read (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .rsp_ready(rsp_ready),
    .plane_rdata(plane_rdata), .regs_q(regs_q), .latch_q(latch_q),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  pgd_write u_write (
    .wr_go(wr_go), .cpu_wdata(cpu_wdata), .latch_q(latch_q), .regs_q(regs_q),
    .plane_wdata(plane_wdata), .plane_we(plane_we)
  );
endmodule

// File: rtl/pgd_chk.sv
module pgd_chk
  import pgd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              cpu_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PIX-1:0]    rsp_data,
  input logic [PW-1:0]     plane_wdata,
  input logic [PLANES-1:0] plane_we,
  input logic [PW-1:0]     latch_q,
  input logic [PLANES-1:0] map_mask,
  input logic [PIX-1:0]    bit_mask,
  input logic [1:0]        wmode
);
  a_r10_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_valid && cpu_ready && cpu_write) |-> plane_we == '0);

  a_r10_strobe_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (plane_we & ~map_mask) == '0);

  a_r9_masked_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
    plane_we != '0 |-> ((plane_wdata ^ latch_q) & ~{PLANES{bit_mask}}) == '0);

  a_r11_copy_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (plane_we != '0 && wmode == 2'd1) |-> plane_wdata == latch_q);

  a_r13_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    wmode == 2'd3 |-> plane_we == '0);

  a_r3_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && !cpu_write) |=> rsp_valid);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind plane_gfx_dp pgd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_write(cpu_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .plane_wdata(plane_wdata), .plane_we(plane_we),
  .latch_q(latch_q), .map_mask(regs_q.map_mask), .bit_mask(regs_q.bit_mask),
  .wmode(regs_q.wmode)
);

// File: tb/sim_plane_gfx_dp.sv
module sim_plane_gfx_dp;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_sel = 0, cpu_valid = 0, cpu_write = 0, rsp_ready = 1;
  logic [7:0] reg_wdata = 0, cpu_wdata = 0;
  logic cpu_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic [31:0] plane_rdata, plane_wdata;
  logic [3:0] plane_we;

  always #4 clk = ~clk;

  plane_gfx_dp u0 (.*);

  logic [7:0] mem [4];
  assign plane_rdata = {mem[3], mem[2], mem[1], mem[0]};
  always @(posedge clk) begin
    for (int p = 0; p < 4; p++) begin
      if (!rst_n) mem[p] <= 8'h00;
      else if (plane_we[p]) mem[p] <= plane_wdata[p*8 +: 8];
    end
  end

  // shadow register model
  logic [1:0] s_wm = 0; logic s_rm = 0; logic [3:0] s_mm = 4'hF; logic [7:0] s_bm = 8'hFF;
  logic [2:0] s_rot = 0; logic [1:0] s_fn = 0; logic [3:0] s_sr = 0, s_esr = 0;
  logic [1:0] s_rsel = 0; logic [3:0] s_cmp = 0, s_dc = 4'hF;
  logic [7:0] s_lat [4] = '{8'h00, 8'h00, 8'h00, 8'h00};

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] expq[$];
  string tagq[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk); reg_wr = 1; reg_sel = 0; reg_wdata = idx;
    @(negedge clk); reg_sel = 1; reg_wdata = val;
    @(negedge clk); reg_wr = 0;
    case (idx)
      8'd0: begin s_wm = val[1:0]; s_rm = val[2]; end
      8'd1: s_mm = val[3:0];
      8'd2: s_bm = val;
      8'd3: begin s_rot = val[2:0]; s_fn = val[4:3]; end
      8'd4: s_sr = val[3:0];
      8'd5: s_esr = val[3:0];
      8'd6: s_rsel = val[1:0];
      8'd7: s_cmp = val[3:0];
      8'd8: s_dc = val[3:0];
      default: ;
    endcase
  endtask

  function automatic logic [7:0] exp_plane(input int p, input logic [7:0] d);
    logic [15:0] t; logic [7:0] src, f;
    if (s_wm == 2'd1) return s_lat[p];
    if (s_wm == 2'd2) src = {8{d[p]}};
    else if (s_esr[p]) src = {8{s_sr[p]}};
    else begin t = {d, d} >> s_rot; src = t[7:0]; end
    case (s_fn)
      2'd1: f = src & s_lat[p];
      2'd2: f = src | s_lat[p];
      2'd3: f = src ^ s_lat[p];
      default: f = src;
    endcase
    return (f & s_bm) | (s_lat[p] & ~s_bm);
  endfunction

  task automatic check_write(input logic [7:0] d, input string tag);
    logic [31:0] ew; logic [3:0] es;
    es = (s_wm == 2'd3) ? 4'h0 : s_mm;
    for (int p = 0; p < 4; p++) ew[p*8 +: 8] = exp_plane(p, d);
    #1;
    chk(plane_we == es, {tag, " strobes"}, {28'd0, plane_we}, {28'd0, es});
    if (es != 0) chk(plane_wdata == ew, {tag, " data"}, plane_wdata, ew);
  endtask

  task automatic cpu_wr(input logic [7:0] d, input string tag);
    @(negedge clk); cpu_valid = 1; cpu_write = 1; cpu_wdata = d;
    check_write(d, tag);
    @(negedge clk); cpu_valid = 0;
  endtask

  function automatic logic [7:0] exp_read();
    logic [7:0] r;
    if (!s_rm) return mem[s_rsel];
    for (int b = 0; b < 8; b++)
      r[b] = ((({mem[3][b], mem[2][b], mem[1][b], mem[0][b]}) ^ s_cmp) & s_dc) == 4'h0;
    return r;
  endfunction

  task automatic cpu_rd(input string tag);
    @(negedge clk); cpu_valid = 1; cpu_write = 0;
    expq.push_back(exp_read()); tagq.push_back(tag);
    for (int p = 0; p < 4; p++) s_lat[p] = mem[p];
    @(negedge clk); cpu_valid = 0;
  endtask

  // monitor: pops expected responses at each handshake
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (expq.size() == 0) chk(0, "R3 unexpected response", {24'd0, rsp_data}, 0);
        else begin
          logic [7:0] e; string t;
          e = expq.pop_front(); t = tagq.pop_front();
          chk(rsp_data == e, t, {24'd0, rsp_data}, {24'd0, e});
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(rsp_valid == 0, "R1 rsp_valid reset", {31'd0, rsp_valid}, 0);
    chk(plane_we == 0, "R1 strobes reset", {28'd0, plane_we}, 0);
    chk(cpu_ready == 1, "R1 cpu_ready reset", {31'd0, cpu_ready}, 1);
    cpu_wr(8'h00, "R1 default write");

    // R10: preload each plane on its own through the map mask
    set_reg(1, 8'h01); cpu_wr(8'hA5, "R10 plane0 only");
    set_reg(1, 8'h02); cpu_wr(8'h3C, "R10 plane1 only");
    set_reg(1, 8'h04); cpu_wr(8'hF0, "R10 plane2 only");
    set_reg(1, 8'h08); cpu_wr(8'h0F, "R10 plane3 only");
    set_reg(1, 8'h0F);

    // R4: read mode 0, each plane
    for (int p = 0; p < 4; p++) begin
      set_reg(6, p[7:0]);
      cpu_rd("R4 read select");
    end

    // R6 rotate
    set_reg(3, 8'h03); cpu_wr(8'h01, "R6 rotate by 3");
    set_reg(3, 8'h07); cpu_wr(8'h81, "R6 rotate by 7");
    set_reg(3, 8'h00);

    // R7 set/reset
    set_reg(4, 8'h01); set_reg(5, 8'h05); cpu_wr(8'h5A, "R7 set/reset");
    set_reg(5, 8'h00);

    // R8 logic functions against latches
    cpu_rd("R3 latch load read");
    set_reg(3, 8'h08); cpu_wr(8'hF0, "R8 AND");
    set_reg(3, 8'h10); cpu_wr(8'hF0, "R8 OR");
    set_reg(3, 8'h18); cpu_wr(8'hF0, "R8 XOR");
    set_reg(3, 8'h00);

    // R9 bit mask
    set_reg(2, 8'h0F); cpu_wr(8'hAA, "R9 bit mask");
    set_reg(2, 8'hFF);

    // R11 latch copy: load latches, overwrite planes, copy back
    cpu_rd("R3 latch load for copy");
    cpu_wr(8'h77, "R11 overwrite");
    set_reg(0, 8'h01); set_reg(1, 8'h06);
    cpu_wr(8'h00, "R11 copy latches");
    set_reg(1, 8'h0F);

    // R12 fill mode
    set_reg(0, 8'h02); set_reg(2, 8'hC3); cpu_wr(8'h05, "R12 fill colour 5");
    set_reg(3, 8'h18); cpu_wr(8'h0A, "R12 fill with XOR");
    set_reg(3, 8'h00); set_reg(2, 8'hFF);

    // R13 no write
    set_reg(0, 8'h03); cpu_wr(8'hFF, "R13 mode 3");

    // R5 colour compare
    cpu_wr(8'h00, "R13 mode 3 again");
    set_reg(0, 8'h00);
    set_reg(1, 8'h01); cpu_wr(8'h5A, "R10 setup p0");
    set_reg(1, 8'h02); cpu_wr(8'hC3, "R10 setup p1");
    set_reg(1, 8'h04); cpu_wr(8'h0F, "R10 setup p2");
    set_reg(1, 8'h08); cpu_wr(8'h33, "R10 setup p3");
    set_reg(1, 8'h0F);
    set_reg(0, 8'h04); set_reg(7, 8'h05);
    cpu_rd("R5 compare all planes");
    set_reg(8, 8'h03); cpu_rd("R5 compare planes 0,1");
    set_reg(8, 8'h00); cpu_rd("R5 no planes compared");
    set_reg(8, 8'h0F); set_reg(0, 8'h00);

    // R2 out-of-range index is ignored
    set_reg(9, 8'h00);
    cpu_wr(8'h12, "R2 index 9 ignored");
    set_reg(8'hFF, 8'h00);
    cpu_wr(8'h34, "R2 index 255 ignored");

    // R14 register write and CPU write in one cycle
    cpu_rd("R3 latch load before R14");
    @(negedge clk); reg_wr = 1; reg_sel = 0; reg_wdata = 8'd2;
    @(negedge clk); reg_sel = 1; reg_wdata = 8'h00;
    cpu_valid = 1; cpu_write = 1; cpu_wdata = 8'hFF;
    check_write(8'hFF, "R14 old bit mask in effect");
    @(negedge clk); reg_wr = 0; cpu_valid = 0; s_bm = 8'h00;
    cpu_wr(8'hFF, "R14 new bit mask later");
    set_reg(2, 8'hFF);

    // R3 back-pressure
    rsp_ready = 0;
    set_reg(6, 8'h02);
    cpu_rd("R3 held response");
    #1;
    chk(rsp_valid == 1, "R3 valid under back-pressure", {31'd0, rsp_valid}, 1);
    chk(cpu_ready == 0, "R3 ready low while pending", {31'd0, cpu_ready}, 0);
    begin
      logic [7:0] held;
      held = rsp_data;
      repeat (3) @(negedge clk);
      #1;
      chk(rsp_valid == 1 && rsp_data == held, "R3 response stable", {24'd0, rsp_data}, {24'd0, held});
    end
    @(negedge clk); rsp_ready = 1;
    repeat (3) @(negedge clk); #1;
    chk(rsp_valid == 0, "R3 response released", {31'd0, rsp_valid}, 0);
    chk(expq.size() == 0, "R3 all responses seen", expq.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule